// File: doc/BRIEF.md
# Paper Tape Line Reader with Read-In Bootstrap

This block takes lines from an eight-hole paper tape source and turns them into words for a 36-bit in-out register. A CPU asks for a transfer with a request pulse and a mode bit. Character mode takes one line and places it, unchanged, in the low byte of the word. Word mode takes six punched lines and packs them into a full word. Tape lines arrive on a valid/ready handshake, and the block raises ready only while a transfer or a bootstrap load is in progress.

A console read-in pulse starts a bootstrap load that needs no program in memory. Tape is read in word mode, and each assembled word is taken in turn as a command and then as a data word. A deposit command writes the data word that follows it to memory through a one-cycle write port. A jump command ends the load and gives the CPU a start pulse with the first instruction address. Any other opcode stops the load and raises an error flag.

Top module: `tape_loader`

## Requirements
- R1: After reset, line_ready_o, done_o, mem_we_o, start_o and error_o are all low and word_o is zero.
- R2: In character mode (req_mode_i = 0), a request accepts exactly one line. Every line is accepted, whatever hole 8 holds. One cycle after the handshake, done_o pulses for one cycle and word_o holds the line in bits 7:0 with zeros in bits 35:8.
- R3: In word mode (req_mode_i = 1), a request completes after six accepted lines. line bits 5:0 (holes 1 to 6) form a 6-bit group. The first accepted line fills word bits 35:30 and each later line fills the next lower group. done_o pulses one cycle after the sixth accepted line.
- R4: In word mode and during read-in, a line with bit 7 (hole 8) clear is consumed and discarded and is not counted. Bit 6 (hole 7) has no effect on the word.
- R5: A read_in_i pulse in the idle state starts a bootstrap load. The first assembled word is a command. read_in_i has priority over req_i when both arrive together.
- R6: A command whose bits 35:30 equal 6'h32 (deposit) takes its address from bits 14:0. The next assembled word is written to that address with a one-cycle mem_we_o pulse. The word after that is again a command.
- R7: A command whose bits 35:30 equal 6'h30 (jump) ends the load. start_o pulses for one cycle, start_addr_o holds bits 14:0, and line_ready_o falls.
- R8: Any other command opcode sets error_o and ends the load without a memory write or a start pulse. error_o stays set until the next read-in pulse clears it.
- R9: A request or read-in pulse that arrives while a word or a load is in progress is ignored. It produces no extra done_o pulse and leaves no pending transfer.
- R10: done_o, mem_we_o and start_o never pulse in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| line_valid_i | input | 1 | Tape line available |
| line_data_i | input | 8 | Tape line, bit n is hole n+1 |
| line_ready_o | output | 1 | Block accepts a line this cycle |
| req_i | input | 1 | Transfer request pulse |
| req_mode_i | input | 1 | 0 character mode, 1 word mode |
| done_o | output | 1 | Transfer complete pulse |
| word_o | output | 36 | Assembled word for the in-out register |
| read_in_i | input | 1 | Console read-in pulse |
| mem_we_o | output | 1 | Bootstrap memory write strobe |
| mem_addr_o | output | 15 | Bootstrap write address |
| mem_data_o | output | 36 | Bootstrap write data |
| start_o | output | 1 | Start-execution pulse |
| start_addr_o | output | 15 | First instruction address |
| error_o | output | 1 | Bad bootstrap command seen |

## Verification
Some properties are checked by assertions on every cycle. The three strobes never overlap, the done pulse lasts one cycle, and a character word has zero upper bits. The line counter stays in range. Ready is low at a start pulse and at the rise of the error flag. Only the bench's scenarios can show how groups are ordered within a word, and that lines without hole 8 are dropped. The same holds for the deposit and jump addresses, for error recovery on a later read-in, and for requests that arrive mid-word and must be ignored.

// File: rtl/tl_pkg.sv
package tl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHAR,
    ST_WORD,
    ST_CMD,
    ST_DATA
  } tl_state_e;
endpackage

// File: rtl/tl_packer.sv
module tl_packer #(
  parameter int GRP_W = 6,
  parameter int GRPS  = 6,
  localparam int WORD_W = GRP_W * GRPS,
  localparam int CNT_W  = $clog2(GRPS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              take_i,
  input  logic [GRP_W-1:0]  grp_i,
  output logic [WORD_W-1:0] word_o,
  output logic              full_o
);
  logic [CNT_W-1:0]  cnt_q;
  logic [WORD_W-1:0] acc_q;

  assign word_o = {acc_q[WORD_W-GRP_W-1:0], grp_i};
  assign full_o = take_i && (cnt_q == CNT_W'(GRPS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      acc_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (take_i) begin
      acc_q <= word_o;
      cnt_q <= full_o ? '0 : cnt_q + 1'b1;
    end
  end

  p_cnt_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CNT_W'(GRPS));
endmodule

// File: rtl/tl_ctrl.sv
module tl_ctrl
  import tl_pkg::*;
#(
  parameter int LINE_W = 8,
  parameter int WORD_W = 36,
  parameter int ADDR_W = 15,
  parameter int OP_W   = 6,
  parameter logic [OP_W-1:0] OP_DEP = 6'h32,
  parameter logic [OP_W-1:0] OP_JMP = 6'h30
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              line_valid_i,
  input  logic [LINE_W-1:0] line_data_i,
  output logic              line_ready_o,
  input  logic              req_i,
  input  logic              req_mode_i,
  input  logic              read_in_i,
  input  logic [WORD_W-1:0] pk_word_i,
  input  logic              pk_full_i,
  output logic              pk_take_o,
  output logic              pk_clr_o,
  output logic              done_o,
  output logic [WORD_W-1:0] word_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [WORD_W-1:0] mem_data_o,
  output logic              start_o,
  output logic [ADDR_W-1:0] start_addr_o,
  output logic              error_o
);
  tl_state_e state_q;
  logic      acc;
  logic      grp_mode;
  logic [OP_W-1:0] op;

  assign line_ready_o = (state_q != ST_IDLE);
  assign acc          = line_valid_i && line_ready_o;
  assign grp_mode     = (state_q == ST_WORD) || (state_q == ST_CMD) || (state_q == ST_DATA);
  assign pk_take_o    = acc && grp_mode && line_data_i[LINE_W-1];
  assign pk_clr_o     = (state_q == ST_IDLE);
  assign op           = pk_word_i[WORD_W-1 -: OP_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      done_o       <= 1'b0;
      word_o       <= '0;
      mem_we_o     <= 1'b0;
      mem_addr_o   <= '0;
      mem_data_o   <= '0;
      start_o      <= 1'b0;
      start_addr_o <= '0;
      error_o      <= 1'b0;
    end else begin
      done_o   <= 1'b0;
      mem_we_o <= 1'b0;
      start_o  <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (read_in_i) begin
            state_q <= ST_CMD;
            error_o <= 1'b0;
          end else if (req_i) begin
            state_q <= req_mode_i ? ST_WORD : ST_CHAR;
          end
        end
        ST_CHAR: if (acc) begin
          word_o  <= {{(WORD_W-LINE_W){1'b0}}, line_data_i};
          done_o  <= 1'b1;
          state_q <= ST_IDLE;
        end
        ST_WORD: if (pk_full_i) begin
          word_o  <= pk_word_i;
          done_o  <= 1'b1;
          state_q <= ST_IDLE;
        end
        ST_CMD: if (pk_full_i) begin
          if (op == OP_DEP) begin
            mem_addr_o <= pk_word_i[ADDR_W-1:0];
            state_q    <= ST_DATA;
          end else if (op == OP_JMP) begin
            start_addr_o <= pk_word_i[ADDR_W-1:0];
            start_o      <= 1'b1;
            state_q      <= ST_IDLE;
          end else begin
            error_o <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        ST_DATA: if (pk_full_i) begin
          mem_data_o <= pk_word_i;
          mem_we_o   <= 1'b1;
          state_q    <= ST_CMD;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  p_char_clear_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CHAR && acc) |=> (done_o && word_o[WORD_W-1:LINE_W] == '0));
  p_done_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_we_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> !mem_we_o);
  p_strobe_excl_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({done_o, mem_we_o, start_o}));
endmodule

// File: rtl/tape_loader.sv
module tape_loader #(
  parameter int LINE_W = 8,
  parameter int GRP_W  = 6,
  parameter int GRPS   = 6,
  parameter int ADDR_W = 15,
  parameter int OP_W   = 6,
  localparam int WORD_W = GRP_W * GRPS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              line_valid_i,
  input  logic [7:0]        line_data_i,
  output logic              line_ready_o,
  input  logic              req_i,
  input  logic              req_mode_i,
  output logic              done_o,
  output logic [35:0]       word_o,
  input  logic              read_in_i,
  output logic              mem_we_o,
  output logic [14:0]       mem_addr_o,
  output logic [35:0]       mem_data_o,
  output logic              start_o,
  output logic [14:0]       start_addr_o,
  output logic              error_o
);
  logic [WORD_W-1:0] pk_word;
  logic pk_full, pk_take, pk_clr;

  tl_packer #(.GRP_W(GRP_W), .GRPS(GRPS)) u_packer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (pk_clr),
    .take_i (pk_take),
    .grp_i  (line_data_i[GRP_W-1:0]),
    .word_o (pk_word),
    .full_o (pk_full)
  );

  tl_ctrl #(
    .LINE_W(LINE_W), .WORD_W(WORD_W), .ADDR_W(ADDR_W), .OP_W(OP_W)
  ) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .line_valid_i (line_valid_i),
    .line_data_i  (line_data_i),
    .line_ready_o (line_ready_o),
    .req_i        (req_i),
    .req_mode_i   (req_mode_i),
    .read_in_i    (read_in_i),
    .pk_word_i    (pk_word),
    .pk_full_i    (pk_full),
    .pk_take_o    (pk_take),
    .pk_clr_o     (pk_clr),
    .done_o       (done_o),
    .word_o       (word_o),
    .mem_we_o     (mem_we_o),
    .mem_addr_o   (mem_addr_o),
    .mem_data_o   (mem_data_o),
    .start_o      (start_o),
    .start_addr_o (start_addr_o),
    .error_o      (error_o)
  );

  p_jump_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> !line_ready_o);
  p_err_halt_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(error_o) |-> !line_ready_o);
endmodule

// File: tb/tb_tape_loader.sv
module tb_tape_loader;
  localparam time CLK_PERIOD = 10ns;
  localparam int  NVEC = 5;
  // {mode, six lines (first in top byte), expected word}
  localparam logic [84:0] VEC [NVEC] = '{
    {1'b0, 48'hA5_0000000000, 36'h0000000A5},
    {1'b0, 48'h41_0000000000, 36'h000000041},
    {1'b0, 48'hFF_0000000000, 36'h0000000FF},
    {1'b1, 48'hBF_80_AA_95_C1_BC, 36'hFC0A9507C},
    {1'b1, 48'h81_82_84_88_90_A0, 36'h042108420}
  };

  logic clk = 0, rst_ni = 0;
  logic line_valid = 0, req = 0, req_mode = 0, read_in = 0;
  logic [7:0] line_data = '0;
  logic line_ready, done, mem_we, start, error;
  logic [35:0] word, mem_data;
  logic [14:0] mem_addr, start_addr;

  int total = 0, fails = 0;
  int n_done = 0, n_we = 0, n_start = 0;
  logic [35:0] last_word = '0, last_mdata = '0;
  logic [14:0] last_maddr = '0, last_saddr = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tape_loader dut (
    .clk_i(clk), .rst_ni(rst_ni), .line_valid_i(line_valid), .line_data_i(line_data),
    .line_ready_o(line_ready), .req_i(req), .req_mode_i(req_mode), .done_o(done),
    .word_o(word), .read_in_i(read_in), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_data_o(mem_data), .start_o(start), .start_addr_o(start_addr), .error_o(error)
  );

  always @(negedge clk) begin
    if (done)   begin n_done++;  last_word = word; end
    if (mem_we) begin n_we++;    last_maddr = mem_addr; last_mdata = mem_data; end
    if (start)  begin n_start++; last_saddr = start_addr; end
  end

  task automatic chk(string tag, logic [35:0] act, logic [35:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic send_line(logic [7:0] d);
    @(negedge clk);
    while (!line_ready) @(negedge clk);
    line_valid = 1; line_data = d;
    @(negedge clk);
    line_valid = 0;
  endtask

  task automatic send_word(logic [35:0] w);
    for (int k = 0; k < 6; k++) send_line({2'b10, w[35-6*k -: 6]});
  endtask

  task automatic pulse_req(logic m);
    @(negedge clk); req = 1; req_mode = m;
    @(negedge clk); req = 0;
  endtask

  task automatic pulse_read_in();
    @(negedge clk); read_in = 1;
    @(negedge clk); read_in = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    int d0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 ready", line_ready, 0);
    chk("R1 strobes", {done, mem_we, start, error}, 0);
    chk("R1 word", word, 0);
    rst_ni = 1;
    @(negedge clk);
    chk("R1 ready after release", line_ready, 0);

    // R2 / R3 vector walk
    for (int i = 0; i < NVEC; i++) begin
      d0 = n_done;
      pulse_req(VEC[i][84]);
      if (!VEC[i][84]) send_line(VEC[i][83:76]);
      else for (int k = 0; k < 6; k++) send_line(VEC[i][83-8*k -: 8]);
      @(negedge clk);
      chk(VEC[i][84] ? "R3 word" : "R2 word", last_word, VEC[i][35:0]);
      chk(VEC[i][84] ? "R3 one done" : "R2 one done", 36'(n_done - d0), 1);
      chk("R2 idle after", line_ready, 0);
    end

    // R4 unmarked lines dropped, hole 7 ignored
    d0 = n_done;
    pulse_req(1);
    send_line(8'h7F); send_line(8'h3F);
    for (int k = 0; k < 5; k++) send_line(8'hC1);
    send_line(8'h41);
    @(negedge clk);
    chk("R4 no early done", 36'(n_done - d0), 0);
    send_line(8'hC1);
    @(negedge clk);
    chk("R4 word", last_word, 36'h041041041);

    // R9 request and read-in mid-word ignored
    d0 = n_done;
    pulse_req(1);
    send_line(8'h81); send_line(8'h82); send_line(8'h84);
    pulse_req(0);
    pulse_read_in();
    send_line(8'h88); send_line(8'h90); send_line(8'hA0);
    @(negedge clk);
    chk("R9 word", last_word, 36'h042108420);
    chk("R9 single done", 36'(n_done - d0), 1);
    repeat (2) @(negedge clk);
    chk("R9 nothing pending", {line_ready, 35'(n_we)}, 0);

    // R5 R6 R7 bootstrap: deposit then jump; read_in beats req
    @(negedge clk); read_in = 1; req = 1; req_mode = 0;
    @(negedge clk); read_in = 0; req = 0;
    send_line(8'h00); // no hole 8: dropped even in read-in
    send_word({6'h32, 15'd0, 15'h1234});
    chk("R5 no write on command", 36'(n_we), 0);
    send_word(36'h987654321);
    @(negedge clk);
    chk("R6 write count", 36'(n_we), 1);
    chk("R6 addr", 36'(last_maddr), 36'h1234);
    chk("R6 data", last_mdata, 36'h987654321);
    chk("R5 no done in read-in", 36'(n_done), 36'(d0 + 1));
    send_word({6'h30, 15'h7FFF, 15'h0100});
    @(negedge clk);
    chk("R7 start count", 36'(n_start), 1);
    chk("R7 start addr", 36'(last_saddr), 36'h0100);
    chk("R7 ready low", line_ready, 0);

    // R8 bad opcode
    pulse_read_in();
    send_word({6'h11, 15'd0, 15'h0055});
    @(negedge clk);
    chk("R8 error set", error, 1);
    chk("R8 halted", line_ready, 0);
    chk("R8 no side effects", {33'(n_we), 3'(n_start)}, {33'd1, 3'd1});
    pulse_read_in();
    chk("R8 error cleared", error, 0);
    send_word({6'h30, 15'd0, 15'h0042});
    @(negedge clk);
    chk("R8 recovery jump", 36'(last_saddr), 36'h0042);
    chk("R10 strobe totals", 36'(n_start), 2);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule